// File: doc/BRIEF.md
# Set/Clear Aliased Control Register Block

This block is a small byte-wide register file behind the control port of a USB transceiver. Each writable register sits behind three neighbouring addresses. The first replaces the whole byte. The second ORs the data byte into the register. The third clears every bit that is a one in the data byte. A read at any of the three addresses returns the same stored value.

The block takes a 6-bit address with separate read and write strobes. It holds three registers:
- a scratch byte that nothing else in the block uses;
- a read-only debug byte that shows the two line-state inputs after synchronization;
- a power-control byte whose enable bits drive an output port.

Addresses with no register behind them ignore writes and read as zero. One pointer address takes the written byte as an extended address. The next access, read or write, goes to that extended address. Extended addresses below 40h fold back onto the normal map.

Top module: `setclr_regfile`

## Requirements
- R1: While reset is asserted and just after it, the scratch and power-control registers hold 00h, no extended pointer is armed, and `rd_data` is 00h.
- R2: A write to 16h loads the scratch register with `wr_data`. A write to 3Dh loads power control with `wr_data` masked to its defined bits.
- R3: A write to 17h (scratch) or 3Eh (power control) ORs `wr_data` into the register. The result shows one cycle after the write strobe.
- R4: A write to 18h (scratch) or 3Fh (power control) clears every register bit whose `wr_data` bit is 1 and leaves the other bits as they were.
- R5: Reads at 16h, 17h and 18h return the scratch value, and reads at 3Dh, 3Eh and 3Fh return the power-control value. `rd_data` is registered: it updates on the clock edge that samples `rd_en` and otherwise holds.
- R6: A read of 15h returns the line-state inputs in bits 1:0 (bit 1 = `line_state[1]`) after a two-flop synchronizer, so a read sees the value sampled two edges earlier. Bits 7:2 read 0. A write to 15h changes nothing.
- R7: Writes to addresses with no register behind them (19h–2Eh, and all other unmapped addresses in 00h–3Fh) change no register, and reads there return 00h.
- R8: The power-control layout is: bit 0 = VBUS-rise event enable, bit 1 = VBUS-fall event enable, bit 2 = ignore-line-state. Bits 7:3 are reserved. They always read 0 and no write, set or clear changes them. The register appears on `pwr_ctrl`.
- R9: A write to 2Fh stores `wr_data` as an extended address and arms the pointer. The next strobe, read or write, uses that address in place of `addr` and disarms the pointer. An extended address below 40h acts exactly like the same immediate address, including 2Fh itself.
- R10: A redirected access to an extended address of 40h or above changes no register and reads 00h.
- R11: The value of the scratch register never affects `pwr_ctrl` or the debug read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 6 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_data | input | 8 | Write data byte |
| line_state | input | 2 | Asynchronous line-state inputs |
| rd_data | output | 8 | Registered read data |
| pwr_ctrl | output | 8 | Current power-control register |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, two synchronizer stages, and a 07h defined-bit mask for power control. With these values the masking of reserved bits can be seen on every write, set and clear. The two-edge delay of the debug read can be seen when line state changes just before a read. Directed sequences cover pointer chains: a pointer that aims at the pointer address, at an aliased register, and at space above 40h. A long run of random accesses then mixes all address classes and line-state changes.

// File: rtl/setclr_pkg.sv
package setclr_pkg;
  localparam int EAW = 8;
  localparam logic [EAW-1:0] DBG_ADDR  = 8'h15;
  localparam logic [EAW-1:0] PTR_ADDR  = 8'h2F;
  localparam logic [EAW-1:0] IMM_LIMIT = 8'h40;
  localparam int NREG = 2;
  localparam logic [EAW-1:0] REG_BASE [NREG] = '{8'h16, 8'h3D};

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_OR   = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } alias_op_e;
endpackage

// File: rtl/setclr_sync.sv
module setclr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/setclr_alias_dec.sv
module setclr_alias_dec
  import setclr_pkg::*;
#(
  parameter logic [EAW-1:0] BASE = 8'h16
) (
  input  logic [EAW-1:0] eff_addr,
  output logic           hit,
  output alias_op_e      op
);
  localparam logic [EAW-1:0] LAST = BASE + EAW'(2);

  always_comb begin
    hit = (eff_addr >= BASE) && (eff_addr <= LAST) && (eff_addr < IMM_LIMIT);
    op  = OP_NONE;
    if (hit) begin
      unique case (eff_addr - BASE)
        8'd0:    op = OP_LOAD;
        8'd1:    op = OP_OR;
        default: op = OP_CLR;
      endcase
    end
  end
endmodule

// File: rtl/setclr_alias_reg.sv
module setclr_alias_reg
  import setclr_pkg::*;
#(
  parameter int          DW   = 8,
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  alias_op_e     op,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_d;
  logic          q_en;

  always_comb begin
    q_en = wr_hit && (op != OP_NONE);
    unique case (op)
      OP_LOAD: q_d = wdata & MASK;
      OP_OR:   q_d = q | (wdata & MASK);
      OP_CLR:  q_d = q & ~wdata;
      default: q_d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/setclr_regfile.sv
module setclr_regfile
  import setclr_pkg::*;
#(
  parameter int          AW          = 6,
  parameter int          DW          = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [DW-1:0] SCR_MASK  = 8'hFF,
  parameter logic [DW-1:0] PWR_MASK  = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    line_state,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] pwr_ctrl
);
  localparam logic [DW-1:0] MASKS [NREG] = '{SCR_MASK, PWR_MASK};
  localparam int PWR_IDX = 1;

  logic           ptr_armed_q, ptr_armed_d;
  logic [EAW-1:0] ptr_q, ptr_d;
  logic [EAW-1:0] eff_addr;
  logic           strobe;
  logic [1:0]     ls_sync;
  logic [DW-1:0]  rd_d;
  logic [DW-1:0]  reg_q   [NREG];
  logic           reg_hit [NREG];
  alias_op_e      reg_op  [NREG];

  assign strobe   = wr_en | rd_en;
  assign eff_addr = ptr_armed_q ? ptr_q : EAW'(addr);

  setclr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ls_sync (
    .clk(clk), .rst_n(rst_n), .din(line_state), .dout(ls_sync)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    setclr_alias_dec #(.BASE(REG_BASE[r])) u_dec (
      .eff_addr(eff_addr), .hit(reg_hit[r]), .op(reg_op[r])
    );
    setclr_alias_reg #(.DW(DW), .MASK(MASKS[r])) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_en && reg_hit[r]),
      .op(reg_op[r]), .wdata(wr_data), .q(reg_q[r])
    );
  end

  // Extended pointer: next-state
  always_comb begin
    ptr_armed_d = ptr_armed_q;
    ptr_d       = ptr_q;
    if (strobe) ptr_armed_d = 1'b0;
    if (wr_en && (eff_addr == PTR_ADDR)) begin
      ptr_armed_d = 1'b1;
      ptr_d       = wr_data[EAW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_armed_q <= 1'b0;
      ptr_q       <= '0;
    end else if (strobe) begin
      ptr_armed_q <= ptr_armed_d;
      ptr_q       <= ptr_d;
    end
  end

  // Read path: next-state
  always_comb begin
    rd_d = '0;
    if (eff_addr == DBG_ADDR) rd_d = DW'(ls_sync);
    for (int r = 0; r < NREG; r++) begin
      if (reg_hit[r]) rd_d = reg_q[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_d;
  end

  assign pwr_ctrl = reg_q[PWR_IDX];
endmodule

// File: rtl/setclr_regfile_chk.sv
module setclr_regfile_chk #(
  parameter int          AW       = 6,
  parameter int          DW       = 8,
  parameter logic [DW-1:0] PWR_MASK = 8'h07
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] pwr_ctrl,
  input logic          ptr_armed
);
  logic direct_wr, direct_rd;
  assign direct_wr = wr_en && !ptr_armed;
  assign direct_rd = rd_en && !ptr_armed;

  // R3
  pwr_set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct_wr && addr == 6'h3E |=> pwr_ctrl == ($past(pwr_ctrl) | ($past(wr_data) & PWR_MASK)));

  // R4
  pwr_clear_andnot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct_wr && addr == 6'h3F |=> pwr_ctrl == ($past(pwr_ctrl) & ~$past(wr_data)));

  // R7
  hole_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct_wr && addr >= 6'h19 && addr <= 6'h2E |=> $stable(pwr_ctrl));

  // R8
  pwr_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ctrl & ~PWR_MASK) == '0);

  // R6
  debug_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct_rd && addr == 6'h15 |=> rd_data[DW-1:2] == '0);

  // R9
  pointer_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct_wr && addr == 6'h2F |=> ptr_armed);

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind setclr_regfile setclr_regfile_chk #(.AW(AW), .DW(DW), .PWR_MASK(PWR_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .rd_data(rd_data), .pwr_ctrl(pwr_ctrl), .ptr_armed(ptr_armed_q)
);

// File: tb/tb_setclr_regfile.sv
module tb_setclr_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] line_state = '0;
  logic [7:0] rd_data, pwr_ctrl;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  setclr_regfile dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .line_state(line_state), .rd_data(rd_data), .pwr_ctrl(pwr_ctrl)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference
  logic [7:0] m_scr, m_pwr, m_rd, m_ptr;
  bit         m_armed;
  logic [1:0] ls_q[$];
  int         e;
  logic [1:0] dbg;

  function automatic logic [7:0] ref_read(int a, logic [1:0] d);
    if (a == 'h15) return {6'b0, d};
    if (a >= 'h16 && a <= 'h18) return m_scr;
    if (a >= 'h3D && a <= 'h3F) return m_pwr;
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_scr = 0; m_pwr = 0; m_rd = 0; m_ptr = 0; m_armed = 0;
      ls_q = '{2'b00, 2'b00};
    end else begin
      e   = m_armed ? int'(m_ptr) : int'(addr);
      dbg = ls_q[0];
      ls_q.push_back(line_state);
      void'(ls_q.pop_front());
      if (wr_en || rd_en) m_armed = 0;
      if (rd_en) m_rd = ref_read(e, dbg);
      if (wr_en) begin
        case (e)
          'h16: m_scr = wr_data;
          'h17: m_scr = m_scr | wr_data;
          'h18: m_scr = m_scr & ~wr_data;
          'h3D: m_pwr = wr_data & 8'h07;
          'h3E: m_pwr = m_pwr | (wr_data & 8'h07);
          'h3F: m_pwr = m_pwr & ~wr_data;
          'h2F: begin m_armed = 1; m_ptr = wr_data; end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(tag, pwr_ctrl, m_pwr, "pwr_ctrl");
      check(tag, rd_data, m_rd, "rd_data");
    end
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
    end
  end

  task automatic wr(logic [5:0] a, logic [7:0] d, string t);
    @(negedge clk); tag = t; addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, string t);
    @(negedge clk); tag = t; addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rd_data, 8'h00, "rd_data in reset");
    check("R1", pwr_ctrl, 8'h00, "pwr_ctrl in reset");
    rst_n = 1'b1;
    rd("16", "R1");
    // R2 / R5 scratch aliases
    wr(6'h16, 8'hA5, "R2");
    rd(6'h16, "R5"); rd(6'h17, "R5"); rd(6'h18, "R5");
    wr(6'h17, 8'h0F, "R3"); rd(6'h16, "R3");
    wr(6'h18, 8'hF0, "R4"); rd(6'h17, "R4");
    // R8 power control masking
    wr(6'h3D, 8'hFF, "R8"); rd(6'h3F, "R8");
    wr(6'h3F, 8'h02, "R4"); rd(6'h3D, "R4");
    wr(6'h3E, 8'hFA, "R3"); rd(6'h3E, "R3");
    // R11 scratch activity leaves pwr_ctrl alone
    wr(6'h16, 8'h00, "R11"); wr(6'h17, 8'hFF, "R11"); rd(6'h3D, "R11");
    // R6 debug with synchronizer latency
    line_state = 2'b10; repeat (3) @(negedge clk); rd(6'h15, "R6");
    wr(6'h15, 8'hFF, "R6"); rd(6'h15, "R6");
    @(negedge clk); line_state = 2'b01; rd(6'h15, "R6"); rd(6'h15, "R6");
    // R7 holes and unmapped
    wr(6'h19, 8'hFF, "R7"); wr(6'h2E, 8'hFF, "R7"); wr(6'h30, 8'h00, "R7");
    rd(6'h20, "R7"); rd(6'h00, "R7"); rd(6'h3C, "R7"); rd(6'h16, "R7");
    // R9 pointer redirect
    wr(6'h2F, 8'h16, "R9"); wr(6'h00, 8'h55, "R9"); rd(6'h16, "R9");
    wr(6'h2F, 8'h3F, "R9"); wr(6'h00, 8'h07, "R9"); rd(6'h3D, "R9");
    wr(6'h2F, 8'h15, "R9"); rd(6'h00, "R9");
    wr(6'h2F, 8'h2F, "R9"); wr(6'h00, 8'h3D, "R9"); rd(6'h00, "R9");
    // R10 beyond the immediate map
    wr(6'h2F, 8'h80, "R10"); wr(6'h3D, 8'h00, "R10"); rd(6'h3D, "R10");
    wr(6'h2F, 8'h7D, "R10"); rd(6'h3D, "R10");
    // Mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      logic [5:0] a = (k < 4) ? 6'($urandom_range(6'h15, 6'h18)) :
                      (k < 7) ? 6'($urandom_range(6'h3D, 6'h3F)) :
                      (k == 7) ? 6'h2F : 6'($urandom);
      if ($urandom_range(0, 3) == 0) line_state = 2'($urandom);
      if ($urandom_range(0, 1) == 0) wr(a, 8'($urandom), "R5");
      else rd(a, "R5");
    end
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule